// File: doc/BRIEF.md
# Quadword Instruction Splitting Decoder

This decode-stage unit accepts one already-decoded instruction per valid/ready handshake. It turns every 16-byte register-pair memory access into two micro-operations for the execute stage. There are four such forms: pair load, pair store, pair load-with-reservation and pair conditional store. Each micro-operation carries its own register number, a repeat flag and a second flag. Every other instruction passes through as one micro-operation, unchanged.

The endianness bit travels with the instruction and sets which half of the register pair goes out first. The unit also catches the register-overlap forms that are not allowed. Those leave as one micro-operation with an illegal marker and are not split. While the second micro-operation of a pair is pending, the upstream ready is held low. A flush discards any pending second micro-operation.

Outputs are registered. An instruction accepted at a clock edge shows up on the outputs after that edge. Its second micro-operation, if any, follows one cycle later.

Top module: `qws_split_decoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Opcode values 0, 5, 6 and 7 are ordinary instructions. An accepted ordinary instruction gives exactly one micro-op in the next cycle. That micro-op has `out_reg` equal to `in_rt`, copies of the opcode, RA, RB and payload, `out_repeat`=0, `out_second`=0 and `out_illegal`=0.
- R3: The split opcodes are 1 (pair load), 2 (pair store), 3 (pair load-with-reservation) and 4 (pair conditional store). A legal accepted split opcode gives two micro-ops in two consecutive cycles. Both carry the same opcode, RA, RB and payload.
- R4: With `in_le`=1, the first micro-op's register is `in_rt` with bit 0 forced to 1. The second micro-op's register is `in_rt` unchanged.
- R5: With `in_le`=0, the first micro-op's register is `in_rt` unchanged. The second micro-op's register is `in_rt` with bit 0 forced to 1.
- R6: `out_repeat` is 1 on both micro-ops of a split pair. `out_second` is 1 only on the second one.
- R7: `in_ready` is 0 in the cycle that presents the first micro-op of a pair. An instruction held valid on the input is accepted only after the second micro-op has been issued.
- R8: Opcode 1 with `in_ra` equal to `in_rt` is illegal. It leaves as one micro-op with `out_illegal`=1, `out_repeat`=0 and `out_reg`=`in_rt`.
- R9: Opcode 3 is illegal when `in_ra` or `in_rb` equals `in_rt`. It leaves as one micro-op with `out_illegal`=1 and `out_repeat`=0.
- R10: While `flush` is 1, `in_ready` is 0. In the next cycle `out_valid` is 0, and a pending second micro-op is never issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Discard pending work and the current input |
| in_valid | input | 1 | Upstream instruction valid |
| in_ready | output | 1 | Unit can accept an instruction |
| in_op | input | 3 | Operation class code |
| in_rt | input | REG_W | Target or source register number |
| in_ra | input | REG_W | First address register |
| in_rb | input | REG_W | Second address register |
| in_le | input | 1 | Little-endian mode for this instruction |
| in_pay | input | PAY_W | Other decoded fields, passed through |
| out_valid | output | 1 | Micro-op valid |
| out_op | output | 3 | Operation class code |
| out_reg | output | REG_W | Register number for this micro-op |
| out_ra | output | REG_W | First address register |
| out_rb | output | REG_W | Second address register |
| out_pay | output | PAY_W | Passed-through fields |
| out_repeat | output | 1 | Micro-op belongs to a split pair |
| out_second | output | 1 | Micro-op is the second of a pair |
| out_illegal | output | 1 | Illegal register-overlap form |

## Verification
The bench uses the default widths: 5-bit register numbers and a 32-bit payload. That puts register 31 in range, so the bench can send an already-odd target, where both micro-ops carry the same number, next to even targets, where the pair really differs. The full 5-bit field also allows RA and RB to match the target exactly, and to match only its odd partner. The wide payload makes any mix-up between a held instruction and a newly offered one show up at once.

// File: rtl/qws_pkg.sv
// Shared operation codes for the quadword splitting decoder.
// Assumes the upstream decoder has already reduced each instruction to
// a small class code; codes not listed here are ordinary instructions.
package qws_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_PLAIN    = 3'd0,
        OP_LDQ      = 3'd1,
        OP_STQ      = 3'd2,
        OP_LDQ_RSV  = 3'd3,
        OP_STQ_COND = 3'd4
    } qop_e;
endpackage

// File: rtl/qws_classify.sv
// Classifies one incoming instruction: whether it is a register-pair
// access that must be cracked, and whether its register fields overlap
// in a way that is not allowed. Purely combinational.
module qws_classify #(
    parameter int REG_W = 5
) (
    input  logic [qws_pkg::OP_W-1:0] op,
    input  logic [REG_W-1:0]         rt,
    input  logic [REG_W-1:0]         ra,
    input  logic [REG_W-1:0]         rb,
    output logic                     illegal,
    output logic                     split
);
    import qws_pkg::*;

    logic is_pair;

    // Decide pair membership and illegal overlap from the opcode and fields.
    always_comb begin
        is_pair = (op == OP_LDQ) || (op == OP_STQ) ||
                  (op == OP_LDQ_RSV) || (op == OP_STQ_COND);
        illegal = ((op == OP_LDQ) && (ra == rt)) ||
                  ((op == OP_LDQ_RSV) && ((ra == rt) || (rb == rt)));
        split   = is_pair && !illegal;
    end
endmodule

// File: rtl/qws_regsel.sv
// Picks the register number for one half of a split pair. The odd
// register goes first in little-endian mode and second in big-endian
// mode; the other half uses the number as given.
module qws_regsel #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] rt,
    input  logic             le,
    input  logic             second,
    output logic [REG_W-1:0] reg_o
);
    logic want_odd;

    // Select between the given number and its odd partner.
    always_comb begin
        want_odd = le ^ second;
        reg_o    = want_odd ? {rt[REG_W-1:1], 1'b1} : rt;
    end
endmodule

// File: rtl/qws_split_decoder.sv
// Quadword splitting decode stage. Accepts one instruction per
// valid/ready handshake and presents registered micro-ops. A legal
// register-pair access is issued as two back-to-back micro-ops while
// upstream is stalled; everything else is issued once. Assumes the
// endianness bit is stable per instruction and that downstream always
// takes a valid micro-op. Flush drops any pending second half.
module qws_split_decoder #(
    parameter int REG_W = 5,
    parameter int PAY_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [qws_pkg::OP_W-1:0] in_op,
    input  logic [REG_W-1:0]         in_rt,
    input  logic [REG_W-1:0]         in_ra,
    input  logic [REG_W-1:0]         in_rb,
    input  logic                     in_le,
    input  logic [PAY_W-1:0]         in_pay,
    output logic                     out_valid,
    output logic [qws_pkg::OP_W-1:0] out_op,
    output logic [REG_W-1:0]         out_reg,
    output logic [REG_W-1:0]         out_ra,
    output logic [REG_W-1:0]         out_rb,
    output logic [PAY_W-1:0]         out_pay,
    output logic                     out_repeat,
    output logic                     out_second,
    output logic                     out_illegal
);
    localparam int OP_W = qws_pkg::OP_W;

    logic                pend;
    logic [OP_W-1:0]     hold_op;
    logic [REG_W-1:0]    hold_rt, hold_ra, hold_rb;
    logic [PAY_W-1:0]    hold_pay;
    logic                hold_le;
    logic                in_illegal, in_split;
    logic [REG_W-1:0]    first_reg, second_reg;

    qws_classify #(.REG_W(REG_W)) u_classify (
        .op      (in_op),
        .rt      (in_rt),
        .ra      (in_ra),
        .rb      (in_rb),
        .illegal (in_illegal),
        .split   (in_split)
    );

    qws_regsel #(.REG_W(REG_W)) u_sel_first (
        .rt     (in_rt),
        .le     (in_le),
        .second (1'b0),
        .reg_o  (first_reg)
    );

    qws_regsel #(.REG_W(REG_W)) u_sel_second (
        .rt     (hold_rt),
        .le     (hold_le),
        .second (1'b1),
        .reg_o  (second_reg)
    );

    // Upstream may hand over only when no second half is owed and no flush.
    assign in_ready = !pend && !flush;

    // Issue register: first halves and plain ops from input, second halves from hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend        <= 1'b0;
            out_valid   <= 1'b0;
            out_op      <= '0;
            out_reg     <= '0;
            out_ra      <= '0;
            out_rb      <= '0;
            out_pay     <= '0;
            out_repeat  <= 1'b0;
            out_second  <= 1'b0;
            out_illegal <= 1'b0;
        end else if (flush) begin
            pend        <= 1'b0;
            out_valid   <= 1'b0;
            out_repeat  <= 1'b0;
            out_second  <= 1'b0;
        end else if (pend) begin
            pend        <= 1'b0;
            out_valid   <= 1'b1;
            out_op      <= hold_op;
            out_reg     <= second_reg;
            out_ra      <= hold_ra;
            out_rb      <= hold_rb;
            out_pay     <= hold_pay;
            out_repeat  <= 1'b1;
            out_second  <= 1'b1;
            out_illegal <= 1'b0;
        end else if (in_valid) begin
            pend        <= in_split;
            out_valid   <= 1'b1;
            out_op      <= in_op;
            out_reg     <= in_split ? first_reg : in_rt;
            out_ra      <= in_ra;
            out_rb      <= in_rb;
            out_pay     <= in_pay;
            out_repeat  <= in_split;
            out_second  <= 1'b0;
            out_illegal <= in_illegal;
        end else begin
            out_valid   <= 1'b0;
            out_repeat  <= 1'b0;
            out_second  <= 1'b0;
        end
    end

    // Capture the instruction being accepted so its second half can be built.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_op  <= '0;
            hold_rt  <= '0;
            hold_ra  <= '0;
            hold_rb  <= '0;
            hold_pay <= '0;
            hold_le  <= 1'b0;
        end else if (in_valid && in_ready) begin
            hold_op  <= in_op;
            hold_rt  <= in_rt;
            hold_ra  <= in_ra;
            hold_rb  <= in_rb;
            hold_pay <= in_pay;
            hold_le  <= in_le;
        end
    end
endmodule

// File: rtl/qws_split_decoder_chk.sv
// Protocol checker for the quadword splitting decoder, attached by bind.
// Observes only the ports of the top module.
module qws_split_decoder_chk #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             in_ready,
    input logic             out_valid,
    input logic [REG_W-1:0] out_reg,
    input logic             out_repeat,
    input logic             out_second,
    input logic             out_illegal
);
    // A first half not followed by a flush is followed by its second half.
    p_second_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_repeat && !out_second && !flush) |=>
        (out_valid && out_repeat && out_second));

    // A second half always comes right after a first half of a pair.
    p_second_after_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_second) |->
        (out_repeat && $past(out_valid && out_repeat && !out_second)));

    // Both halves name the same register pair.
    p_pair_same_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_second) |->
        (out_reg[REG_W-1:1] == $past(out_reg[REG_W-1:1])));

    // Upstream is stalled while a first half is on the outputs.
    p_stall_on_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_repeat && !out_second) |-> !in_ready);

    // Illegal forms are never cracked.
    p_illegal_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> !out_repeat);

    // Nothing is issued in the cycle after a flush.
    p_flush_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);
endmodule

bind qws_split_decoder qws_split_decoder_chk #(.REG_W(REG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_reg     (out_reg),
    .out_repeat  (out_repeat),
    .out_second  (out_second),
    .out_illegal (out_illegal)
);

// File: tb/qws_split_decoder_test.sv
// Cycle-by-cycle reference model bench for the quadword splitting decoder.
module qws_split_decoder_test;
    localparam int REG_W = 5;
    localparam int PAY_W = 32;

    typedef struct packed {
        logic [2:0]       op;
        logic [REG_W-1:0] rg;
        logic [REG_W-1:0] ra;
        logic [REG_W-1:0] rb;
        logic [PAY_W-1:0] pay;
        logic             rep;
        logic             sec;
        logic             ill;
        logic             le;
    } uop_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             flush = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [2:0]       in_op = '0;
    logic [REG_W-1:0] in_rt = '0, in_ra = '0, in_rb = '0;
    logic             in_le = 1'b0;
    logic [PAY_W-1:0] in_pay = '0;
    logic             out_valid;
    logic [2:0]       out_op;
    logic [REG_W-1:0] out_reg, out_ra, out_rb;
    logic [PAY_W-1:0] out_pay;
    logic             out_repeat, out_second, out_illegal;

    int   vectors = 0;
    int   errors  = 0;
    uop_t q[$];
    uop_t exp_u;
    logic exp_v = 1'b0;

    always #5 clk = ~clk;

    qws_split_decoder #(.REG_W(REG_W), .PAY_W(PAY_W)) uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
        .in_ready(in_ready), .in_op(in_op), .in_rt(in_rt), .in_ra(in_ra),
        .in_rb(in_rb), .in_le(in_le), .in_pay(in_pay), .out_valid(out_valid),
        .out_op(out_op), .out_reg(out_reg), .out_ra(out_ra), .out_rb(out_rb),
        .out_pay(out_pay), .out_repeat(out_repeat), .out_second(out_second),
        .out_illegal(out_illegal)
    );

    // Reference model: a queue of owed micro-ops, advanced once per clock.
    always @(posedge clk) begin
        if (!rst_n || flush) begin
            q.delete();
            exp_v = 1'b0;
        end else if (q.size() > 0) begin
            exp_u = q.pop_front();
            exp_v = 1'b1;
        end else if (in_valid) begin
            uop_t a;
            logic bad, pair;
            bad  = (in_op == 3'd1 && in_ra == in_rt) ||
                   (in_op == 3'd3 && (in_ra == in_rt || in_rb == in_rt));
            pair = (in_op >= 3'd1 && in_op <= 3'd4) && !bad;
            a.op = in_op; a.ra = in_ra; a.rb = in_rb; a.pay = in_pay;
            a.ill = bad; a.le = in_le; a.rep = pair; a.sec = 1'b0;
            a.rg = (pair && in_le) ? (in_rt | 1) : in_rt;
            exp_u = a;
            exp_v = 1'b1;
            if (pair) begin
                a.sec = 1'b1;
                a.rg  = in_le ? in_rt : (in_rt | 1);
                q.push_back(a);
            end
        end else begin
            exp_v = 1'b0;
        end
    end

    function automatic string tag_of(input logic v, input uop_t u);
        if (!v)        return "R10";
        if (u.ill)     return (u.op == 3'd1) ? "R8" : "R9";
        if (u.rep && u.sec) return u.le ? "R4/R6" : "R5/R6";
        if (u.rep)     return u.le ? "R3/R4" : "R3/R5";
        return "R2";
    endfunction

    // Compare outputs, drive the next inputs, then check the ready signal.
    task automatic step(input logic v, input logic [2:0] op,
                        input logic [REG_W-1:0] rt, input logic [REG_W-1:0] ra,
                        input logic [REG_W-1:0] rb, input logic le,
                        input logic fl, output logic acc);
        uop_t got;
        logic exp_rdy;
        @(negedge clk);
        vectors++;
        got = '{op: out_op, rg: out_reg, ra: out_ra, rb: out_rb, pay: out_pay,
                rep: out_repeat, sec: out_second, ill: out_illegal, le: exp_u.le};
        if (out_valid !== exp_v || (exp_v && got !== exp_u)) begin
            errors++;
            $display("FAIL %s: got valid=%b uop=%h, expected valid=%b uop=%h",
                     tag_of(exp_v, exp_u), out_valid, got, exp_v, exp_u);
        end
        in_valid = v; in_op = op; in_rt = rt; in_ra = ra; in_rb = rb;
        in_le = le; flush = fl; in_pay = {rt, ra, rb, 3'b0, op, 8'h5A, le, 7'(vectors)};
        #1;
        vectors++;
        exp_rdy = (q.size() == 0) && !fl;
        if (in_ready !== exp_rdy) begin
            errors++;
            $display("FAIL %s: in_ready=%b expected %b",
                     fl ? "R10" : "R7", in_ready, exp_rdy);
        end
        acc = v && exp_rdy;
    endtask

    // Offer one instruction and hold it until it is accepted.
    task automatic send(input logic [2:0] op, input logic [REG_W-1:0] rt,
                        input logic [REG_W-1:0] ra, input logic [REG_W-1:0] rb,
                        input logic le);
        logic acc;
        acc = 1'b0;
        while (!acc) step(1'b1, op, rt, ra, rb, le, 1'b0, acc);
    endtask

    task automatic idle(input int n);
        logic acc;
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, '0, '0, '0, 1'b0, 1'b0, acc);
    endtask

    initial begin
        logic acc;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state seen at the ports
        vectors++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            errors++;
            $display("FAIL R1: out_valid=%b in_ready=%b expected 0 1", out_valid, in_ready);
        end
        // R2: ordinary codes back to back
        send(3'd0, 5'd4, 5'd4, 5'd9, 1'b1);
        send(3'd5, 5'd7, 5'd2, 5'd3, 1'b0);
        send(3'd7, 5'd31, 5'd31, 5'd31, 1'b1);
        idle(2);
        // R3/R4/R5/R6/R7: every split code, both modes, even and odd targets
        for (int m = 0; m < 2; m++) begin
            for (int c = 1; c <= 4; c++) begin
                send(3'(c), 5'd6, 5'd1, 5'd2, m[0]);
                send(3'(c), 5'd31, 5'd3, 5'd4, m[0]);
            end
            idle(1);
        end
        // R7: plain op queued behind a pair
        send(3'd2, 5'd10, 5'd20, 5'd21, 1'b1);
        send(3'd0, 5'd11, 5'd12, 5'd13, 1'b0);
        idle(2);
        // R8: pair load with base equal to target, both modes
        send(3'd1, 5'd8, 5'd8, 5'd0, 1'b1);
        send(3'd1, 5'd8, 5'd8, 5'd0, 1'b0);
        // base equal only to odd partner stays legal
        send(3'd1, 5'd8, 5'd9, 5'd0, 1'b1);
        // R9: reservation load overlaps
        send(3'd3, 5'd14, 5'd14, 5'd2, 1'b0);
        send(3'd3, 5'd14, 5'd2, 5'd14, 1'b1);
        send(3'd3, 5'd14, 5'd15, 5'd15, 1'b1);
        // overlap on a store form is not illegal
        send(3'd2, 5'd16, 5'd16, 5'd16, 1'b0);
        idle(2);
        // R10: flush between the two halves, with a new instruction offered
        send(3'd1, 5'd18, 5'd1, 5'd1, 1'b1);
        step(1'b1, 3'd0, 5'd3, 5'd3, 5'd3, 1'b0, 1'b1, acc);
        idle(2);
        // R10: flush while idle with an offered instruction
        step(1'b1, 3'd2, 5'd20, 5'd0, 5'd0, 1'b0, 1'b1, acc);
        send(3'd4, 5'd22, 5'd5, 5'd6, 1'b0);
        idle(3);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule